// File: doc/BRIEF.md
# Host Bus Memory Window Bridge

This block sits between an 8-bit host processor bus and a graphics memory. It watches every host memory cycle and claims only those whose address falls inside a window of the physical address space. The base and length of that window are fixed when the block is built. Cycles that the window claims are served from a graphics RAM. That RAM is reached through a simple request/ready port, so it can be on-chip storage or a slower external memory behind an arbiter.

The window is split into three areas, measured as an offset from its base:
- The implemented RAM starts at offset zero.
- A read-only area follows it and always reads back as 0xFF.
- The last 16 bytes hold a fixed identification string, which software reads to detect that the card is present.

The host strobes arrive without any timing relation to the block clock. They are synchronised, and their leading edges are detected, so one host cycle starts exactly one action. While a RAM read is in flight, the block pulls its active-low WAIT output to stall the processor. It releases WAIT in the same clock cycle that it latches the returned byte.

Top module: `hostwin_bridge`

## Requirements
- R1: After a synchronous reset, the data-bus enable is 0, the WAIT output is 1 (released) and no RAM request is raised.
- R2: A host cycle whose address lies below the window base, or at or above base plus window size, raises no RAM request and never enables the data bus.
- R3: A host write at window offset below the RAM size raises exactly one RAM request. That request has the write flag set, carries the offset as its RAM address, and carries the host data byte.
- R4: A host read at window offset below the RAM size raises one RAM read request at that offset. WAIT is held low until RAM ready is seen. WAIT goes high, and the data bus is enabled with the returned byte, at the clock edge where ready is sampled.
- R5: A host read at an offset from the RAM size up to the start of the last 16 bytes of the window returns 0xFF and raises no RAM request.
- R6: A host read in the last 16 bytes of the window returns byte k of the string "GFXWIN BRIDGE V1", where k is the offset minus (window size − 16). Byte 0 is 'G'. No RAM request is raised.
- R7: Host writes to the 0xFF area or to the identification area raise no RAM request, and the identification bytes read back unchanged afterwards.
- R8: Once the data bus is enabled for a read, the output byte stays constant and the enable stays on until the read strobe is released. After the release, the enable drops.
- R9: A host strobe held active for many clock cycles produces exactly one RAM request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host physical address |
| host_din | input | 8 | Host write data |
| host_mreq_n | input | 1 | Active-low memory-cycle qualifier |
| host_rd_n | input | 1 | Active-low read strobe |
| host_wr_n | input | 1 | Active-low write strobe |
| host_dout | output | 8 | Read data returned to the host |
| host_doe | output | 1 | Data-bus output enable |
| host_wait_n | output | 1 | Active-low wait request to the host |
| ram_req | output | 1 | RAM request, held until ready |
| ram_we | output | 1 | RAM request is a write |
| ram_addr | output | RAM_AW | RAM byte address (window offset) |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid with ready |
| ram_ready | input | 1 | RAM completes the current request |

## Verification
The assertions make three assumptions about the host:
- Address and write data are stable from before a strobe falls until after it rises.
- The read and write strobes are never active together.
- A new host cycle begins only after the previous strobe has been released.

They also assume the RAM side pulses ready only while a request is outstanding. The bench drives every host cycle from a single task that sets address and data first, lowers exactly one strobe, and holds it until the bridge has finished. Its RAM model answers with a one-cycle ready pulse after a fixed latency.

// File: rtl/hwb_pkg.sv
package hwb_pkg;

    typedef enum logic [1:0] {
        RG_OUT   = 2'd0,
        RG_RAM   = 2'd1,
        RG_EMPTY = 2'd2,
        RG_TAG   = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_RAM = 2'd1,
        ST_WR_RAM = 2'd2,
        ST_HOLD   = 2'd3
    } ctl_state_e;

    typedef struct packed {
        logic    is_wr;
        region_e region;
    } hcmd_t;

    localparam int TAG_LEN = 16;
    localparam logic [8*TAG_LEN-1:0] TAG_STR = "GFXWIN BRIDGE V1";
    localparam logic [7:0] FILL_BYTE = 8'hFF;

    function automatic logic [7:0] tag_byte(input logic [3:0] idx);
        return TAG_STR[8*(TAG_LEN-1-int'(idx)) +: 8];
    endfunction

endpackage

// File: rtl/hwb_sync.sv
module hwb_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] d_sync
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], d_async[b]};
        end
        assign d_sync[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/hwb_decode.sv
module hwb_decode
    import hwb_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int WIN_BASE  = 32'h0018_0000,
    parameter int WIN_BYTES = 32'h0008_0000,
    parameter int RAM_BYTES = 32'h0002_0000,
    parameter int RAM_AW    = 17
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [RAM_AW-1:0] ram_off,
    output logic [3:0]        tag_idx
);
    localparam logic [ADDR_W:0] BASE_X  = (ADDR_W+1)'(WIN_BASE);
    localparam logic [ADDR_W:0] END_X   = (ADDR_W+1)'(WIN_BASE + WIN_BYTES);
    localparam logic [ADDR_W:0] TAG0_X  = (ADDR_W+1)'(WIN_BYTES - TAG_LEN);
    localparam logic [ADDR_W:0] RAMTOP_X = (ADDR_W+1)'(RAM_BYTES);

    logic [ADDR_W:0] ax;
    logic [ADDR_W:0] diff;

    assign ax      = {1'b0, addr};
    assign diff    = ax - BASE_X;
    assign ram_off = diff[RAM_AW-1:0];
    assign tag_idx = diff[3:0];

    always_comb begin
        if (ax < BASE_X || ax >= END_X) region = RG_OUT;
        else if (diff >= TAG0_X)        region = RG_TAG;
        else if (diff < RAMTOP_X)       region = RG_RAM;
        else                            region = RG_EMPTY;
    end
endmodule

// File: rtl/hwb_ctrl.sv
module hwb_ctrl
    import hwb_pkg::*;
#(
    parameter int RAM_AW = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  hcmd_t             cmd,
    input  logic              busy_strobe,
    input  logic [RAM_AW-1:0] ram_off,
    input  logic [3:0]        tag_idx,
    input  logic [7:0]        wdata_in,
    output logic [7:0]        host_dout,
    output logic              host_doe,
    output logic              host_wait_n,
    output logic              ram_req,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    input  logic              ram_ready
);
    ctl_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            host_dout <= '0;
            host_doe  <= 1'b0;
            ram_req   <= 1'b0;
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    unique case (cmd.region)
                        RG_RAM: begin
                            ram_req   <= 1'b1;
                            ram_we    <= cmd.is_wr;
                            ram_addr  <= ram_off;
                            ram_wdata <= wdata_in;
                            state     <= cmd.is_wr ? ST_WR_RAM : ST_RD_RAM;
                        end
                        RG_EMPTY: begin
                            if (!cmd.is_wr) begin
                                host_dout <= FILL_BYTE;
                                host_doe  <= 1'b1;
                            end
                            state <= ST_HOLD;
                        end
                        RG_TAG: begin
                            if (!cmd.is_wr) begin
                                host_dout <= tag_byte(tag_idx);
                                host_doe  <= 1'b1;
                            end
                            state <= ST_HOLD;
                        end
                        default: state <= ST_IDLE;
                    endcase
                end
                ST_RD_RAM: if (ram_ready) begin
                    ram_req   <= 1'b0;
                    host_dout <= ram_rdata;
                    host_doe  <= 1'b1;
                    state     <= ST_HOLD;
                end
                ST_WR_RAM: if (ram_ready) begin
                    ram_req <= 1'b0;
                    state   <= ST_HOLD;
                end
                ST_HOLD: if (!busy_strobe) begin
                    host_doe <= 1'b0;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign host_wait_n = (state != ST_RD_RAM);

    // R4: an open request keeps its address until ready
    p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
        ram_req && !ram_ready |=> ram_req && $stable(ram_addr));
    // R4: WAIT is only pulled while a RAM read is outstanding
    p_wait_read_r4: assert property (@(posedge clk) disable iff (rst)
        !host_wait_n |-> ram_req && !ram_we);
    // R9: a completed request is not reissued
    p_one_req_r9: assert property (@(posedge clk) disable iff (rst)
        ram_req && ram_ready |=> !ram_req);
    // R8: returned byte is steady while driven
    p_dout_stable_r8: assert property (@(posedge clk) disable iff (rst)
        host_doe |=> !host_doe || $stable(host_dout));
    // R8: bus is never driven while the host is stalled
    p_doe_nowait_r8: assert property (@(posedge clk) disable iff (rst)
        host_doe |-> host_wait_n);
endmodule

// File: rtl/hostwin_bridge.sv
module hostwin_bridge
    import hwb_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int WIN_BASE  = 32'h0018_0000,
    parameter int WIN_BYTES = 32'h0008_0000,
    parameter int RAM_BYTES = 32'h0002_0000,
    parameter int SYNC_STG  = 2,
    localparam int RAM_AW   = $clog2(RAM_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_din,
    input  logic              host_mreq_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    output logic [7:0]        host_dout,
    output logic              host_doe,
    output logic              host_wait_n,
    output logic              ram_req,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    input  logic              ram_ready
);
    logic [2:0] strb_s;
    logic       rd_act, wr_act, rd_prev, wr_prev, rd_start, wr_start;
    region_e    region;
    logic [RAM_AW-1:0] ram_off;
    logic [3:0] tag_idx;
    hcmd_t      cmd;

    hwb_sync #(.N(3), .STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst(rst),
        .d_async({host_mreq_n, host_rd_n, host_wr_n}),
        .d_sync(strb_s)
    );

    assign rd_act = !strb_s[2] && !strb_s[1];
    assign wr_act = !strb_s[2] && !strb_s[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_prev <= 1'b0;
            wr_prev <= 1'b0;
        end else begin
            rd_prev <= rd_act;
            wr_prev <= wr_act;
        end
    end

    assign rd_start = rd_act && !rd_prev;
    assign wr_start = wr_act && !wr_prev && !rd_start;

    hwb_decode #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES),
        .RAM_BYTES(RAM_BYTES), .RAM_AW(RAM_AW)
    ) u_dec (
        .addr(host_addr), .region(region), .ram_off(ram_off), .tag_idx(tag_idx)
    );

    assign cmd.is_wr  = wr_start;
    assign cmd.region = region;

    hwb_ctrl #(.RAM_AW(RAM_AW)) u_ctrl (
        .clk(clk), .rst(rst),
        .start(rd_start || wr_start), .cmd(cmd),
        .busy_strobe(rd_act || wr_act),
        .ram_off(ram_off), .tag_idx(tag_idx), .wdata_in(host_din),
        .host_dout(host_dout), .host_doe(host_doe), .host_wait_n(host_wait_n),
        .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .ram_ready(ram_ready)
    );

    // R2: cycles outside the window are not claimed
    p_outside_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_start || wr_start) && region == RG_OUT |=> !ram_req && !host_doe);
    // R5: fill area answers at once with 0xFF
    p_fill_r5: assert property (@(posedge clk) disable iff (rst)
        rd_start && region == RG_EMPTY |=> host_doe && host_dout == 8'hFF && !ram_req);
    // R6: identification area answers with the string byte
    p_tag_r6: assert property (@(posedge clk) disable iff (rst)
        rd_start && region == RG_TAG |=> host_doe && host_dout == tag_byte($past(tag_idx)));
    // R7: discarded writes raise no request
    p_discard_r7: assert property (@(posedge clk) disable iff (rst)
        wr_start && (region == RG_EMPTY || region == RG_TAG) |=> !ram_req);
endmodule

// File: tb/sim_hostwin_bridge.sv
`timescale 1ns/1ps
module sim_hostwin_bridge;
    localparam int LAT = 3;
    localparam logic [21:0] BASE = 22'h180000;

    logic        clk = 0, rst = 1;
    logic [21:0] host_addr = '0;
    logic [7:0]  host_din = '0;
    logic        host_mreq_n = 1, host_rd_n = 1, host_wr_n = 1;
    logic [7:0]  host_dout, ram_wdata, ram_rdata;
    logic        host_doe, host_wait_n, ram_req, ram_we, ram_ready;
    logic [16:0] ram_addr;

    int checks = 0, errors = 0;
    int req_cnt = 0;
    logic        last_we;
    logic [16:0] last_addr;
    logic [7:0]  last_wdata;
    logic [7:0]  mem [0:1023];
    logic [7:0]  ref_mem [0:1023];
    logic [7:0]  exp_q[$];
    string       tag_q[$];
    string       id_str = "GFXWIN BRIDGE V1";
    int          rcnt = 0;
    logic        doe_prev = 0;

    always #2.5 clk = ~clk;

    hostwin_bridge u0 (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_din(host_din),
        .host_mreq_n(host_mreq_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_dout(host_dout), .host_doe(host_doe), .host_wait_n(host_wait_n),
        .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .ram_ready(ram_ready)
    );

    // RAM model: ready pulse LAT cycles after a request
    always_ff @(posedge clk) begin
        if (rst) begin
            ram_ready <= 0; rcnt <= 0; ram_rdata <= 0;
        end else if (ram_ready) begin
            ram_ready <= 0; rcnt <= 0;
        end else if (ram_req) begin
            if (rcnt == LAT - 1) begin
                ram_ready <= 1;
                if (ram_we) mem[ram_addr[9:0]] <= ram_wdata;
                else        ram_rdata <= mem[ram_addr[9:0]];
            end else rcnt <= rcnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor: handshakes and scoreboard
    always @(negedge clk) begin
        if (ram_req && ram_ready) begin
            req_cnt++; last_we = ram_we; last_addr = ram_addr; last_wdata = ram_wdata;
        end
        if (host_doe && !doe_prev) begin
            if (exp_q.size() == 0) chk(0, "R2 unexpected bus drive", {24'd0, host_dout}, 0);
            else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front(); t = tag_q.pop_front();
                chk(host_dout == e, t, {24'd0, host_dout}, {24'd0, e});
                chk(host_wait_n == 1, "R4 wait released with data", {31'd0, host_wait_n}, 1);
            end
        end
        doe_prev = host_doe;
    end

    function automatic int region_of(input logic [21:0] a);
        if (a < BASE || a >= BASE + 22'h80000) return 0;
        if (a - BASE >= 22'h7FFF0) return 3;
        if (a - BASE < 22'h20000) return 1;
        return 2;
    endfunction

    task automatic host_cyc(input bit is_wr, input logic [21:0] a, input logic [7:0] d,
                            input int hold, input string tag);
        int rg, base_cnt;
        bit saw_wait;
        logic [7:0] e;
        rg = region_of(a);
        base_cnt = req_cnt;
        saw_wait = 0;
        e = 8'hFF;
        if (rg == 1) e = ref_mem[a[9:0]];
        if (rg == 3) e = id_str[int'(a - BASE - 22'h7FFF0)];
        @(negedge clk);
        host_addr = a; host_din = d;
        @(negedge clk);
        host_mreq_n = 0;
        if (is_wr) host_wr_n = 0; else host_rd_n = 0;
        if (!is_wr && rg != 0) begin
            int n;
            exp_q.push_back(e); tag_q.push_back(tag);
            n = 0;
            while (!host_doe && n < 40) begin
                @(negedge clk);
                if (!host_wait_n) saw_wait = 1;
                n++;
            end
            chk(host_doe == 1, {tag, " bus enabled"}, {31'd0, host_doe}, 1);
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                chk(host_doe && host_dout == e, "R8 data held while strobe active",
                    {23'd0, host_doe, host_dout}, {23'd1, e});
            end
            if (rg == 1) begin
                chk(saw_wait, "R4 wait asserted during RAM read", {31'd0, saw_wait}, 1);
                chk(last_we == 0 && last_addr == 17'(a - BASE), "R4 read request address",
                    {14'd0, last_we, last_addr}, {15'd0, 17'(a - BASE)});
            end
        end else begin
            for (int i = 0; i < hold + 12; i++) begin
                @(negedge clk);
                if (rg == 0 || is_wr) chk(!host_doe, {tag, " no bus drive"}, {31'd0, host_doe}, 0);
            end
        end
        host_mreq_n = 1; host_rd_n = 1; host_wr_n = 1;
        repeat (6) @(negedge clk);
        chk(!host_doe, "R8 enable drops after release", {31'd0, host_doe}, 0);
        chk(req_cnt - base_cnt == (rg == 1 ? 1 : 0), {tag, " request count (R9)"},
            req_cnt - base_cnt, (rg == 1 ? 1 : 0));
        if (is_wr && rg == 1) begin
            chk(last_we && last_addr == 17'(a - BASE) && last_wdata == d, "R3 write request fields",
                {6'd0, last_we, last_addr, last_wdata}, {7'd1, 17'(a - BASE), d});
            ref_mem[a[9:0]] = d;
        end
    endtask

    initial begin
        #200000;
        chk(0, "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin mem[i] = 8'h00; ref_mem[i] = 8'h00; end
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!host_doe && host_wait_n && !ram_req, "R1 reset state",
            {29'd0, host_doe, host_wait_n, ram_req}, 3'b010);

        host_cyc(1, BASE + 22'h10, 8'hA5, 0, "R3 write RAM");
        host_cyc(0, BASE + 22'h10, 8'h00, 3, "R4 read RAM");
        host_cyc(1, BASE + 22'h1FFFF, 8'h3C, 0, "R3 write last RAM byte");
        host_cyc(0, BASE + 22'h1FFFF, 8'h00, 0, "R4 read last RAM byte");
        host_cyc(0, BASE + 22'h20000, 8'h00, 0, "R5 first fill byte");
        host_cyc(0, BASE + 22'h7FFEF, 8'h00, 2, "R5 last fill byte");
        for (int k = 0; k < 16; k++)
            host_cyc(0, BASE + 22'h7FFF0 + 22'(k), 8'h00, 0, "R6 id byte");
        host_cyc(1, BASE + 22'h30000, 8'h11, 0, "R7 write fill area");
        host_cyc(1, BASE + 22'h7FFF0, 8'h22, 0, "R7 write id area");
        host_cyc(0, BASE + 22'h7FFF0, 8'h00, 0, "R7 id byte unchanged");
        host_cyc(0, BASE - 22'h1, 8'h00, 0, "R2 read below window");
        host_cyc(0, BASE + 22'h80000, 8'h00, 0, "R2 read above window");
        host_cyc(1, BASE + 22'h80000, 8'h77, 0, "R2 write above window");
        host_cyc(1, BASE + 22'h40, 8'h99, 20, "R9 long write strobe");
        host_cyc(0, BASE + 22'h40, 8'h00, 20, "R9 long read strobe");
        host_cyc(1, BASE + 22'h100, 8'h55, 0, "R3 pattern 55");
        host_cyc(1, BASE + 22'h101, 8'hAA, 0, "R3 pattern AA");
        host_cyc(1, BASE + 22'h102, 8'hFF, 0, "R3 pattern FF");
        host_cyc(0, BASE + 22'h100, 8'h00, 0, "R4 pattern 55");
        host_cyc(0, BASE + 22'h101, 8'h00, 0, "R4 pattern AA");
        host_cyc(0, BASE + 22'h102, 8'h00, 1, "R4 pattern FF");
        host_cyc(0, BASE + 22'h103, 8'h00, 0, "R4 unwritten byte");

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule